// File: doc/BRIEF.md
# L2 Request Arbiter with Data Reload Table

This block sits in front of the L2 tag lookup. Three requesters compete for that lookup: snoops coming in from the system bus, line misses from the L1 data cache, and fetch misses from the L1 instruction cache. Each cycle the block issues at most one registered grant to the lookup, chosen by fixed priority. Snoops win first. Pending data-cache misses come second. Instruction fetches come last.

Data-cache misses do not wait at the arbiter. They are written straight into an eight-entry reload table and then compete for the lookup from there. Because of this, the data cache can hand over a miss in the same cycle that an instruction fetch is granted. Each table entry holds a line address, a load/store kind, a valid bit and an issued bit. An entry stays busy until a completion naming its index retires it. A new data miss to a line that is already held in the table is merged into that entry and returned its index; no second entry is allocated.

Top module: `l2_req_arbiter`

## Requirements
- R1: When `snp_valid` is high in a cycle, the grant registered at the end of that cycle has `gnt_valid`=1 and `gnt_src`=1 (snoop), with `gnt_addr`=`snp_addr`. This holds whatever the other requesters present.
- R2: With no snoop, the lowest-index table entry that is valid and not yet issued is granted with `gnt_src`=2 (data). The grant carries that entry's address and kind, and `gnt_tag` is the entry index.
- R3: `ic_ready` is high only when `ic_valid` is high, no snoop is present and no data entry awaits issue. The grant that follows has `gnt_src`=3 (instruction) and `gnt_addr`=`ic_addr`. An instruction request that is refused is held by the requester and granted later.
- R4: In a cycle with no snoop, no pending data entry and a non-full table, an instruction request and a data request are both accepted: `ic_ready`=1 and `dc_ready`=1.
- R5: At most one grant is issued per cycle. `gnt_src`=0 whenever `gnt_valid`=0.
- R6: Up to eight data misses can be outstanding. A new miss takes the lowest free entry, and `dc_tag` shows that index while `dc_ready` is high. A newly written entry is granted no earlier than the cycle after it was written.
- R7: When all eight entries are busy, `dc_ready` is low for any address whose line is not already in the table.
- R8: Lines are compared on address bits above the low 5 (32-byte lines). A data request whose line matches a busy entry is accepted even when the table is full. `dc_tag` gives the matching index, no entry is allocated, and no extra grant follows. The entry keeps the kind of its first request.
- R9: `cpl_valid` with `cpl_tag` frees that entry at the clock edge. A miss presented in the following cycle may reuse the freed entry. An entry being retired in the current cycle is not a merge target.
- R10: Each allocated entry is granted exactly once, whatever the order in which entries retire.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| snp_valid | input | 1 | Bus snoop present (always taken) |
| snp_addr | input | 32 | Snoop address |
| dc_valid | input | 1 | Data-cache miss present |
| dc_addr | input | 32 | Data-cache miss address |
| dc_store | input | 1 | Miss kind: 1 store, 0 load |
| dc_ready | output | 1 | Table can take or merge the miss on `dc_addr` |
| dc_tag | output | 3 | Entry index allocated or merged |
| ic_valid | input | 1 | Instruction fetch miss present |
| ic_addr | input | 32 | Fetch address |
| ic_ready | output | 1 | Fetch granted this cycle |
| cpl_valid | input | 1 | Reload completion |
| cpl_tag | input | 3 | Entry index to retire |
| gnt_valid | output | 1 | Registered grant to the tag lookup |
| gnt_src | output | 2 | 0 none, 1 snoop, 2 data, 3 instruction |
| gnt_addr | output | 32 | Granted address |
| gnt_store | output | 1 | Granted kind (data grants only) |
| gnt_tag | output | 3 | Table index for data grants, else 0 |

## Verification
The bench runs every combination of the three requesters against an empty table. A design with a wrong priority order, or one that stalls the data cache while an instruction fetch is granted, shows a wrong `gnt_src` or a wrong `ic_ready` there. It then fills all eight entries and checks that the ninth distinct line is refused. It also checks that a same-line request is merged into entry 3 rather than refused, and that the merge produces no second grant. A table that leaked or duplicated entries would either stall there or emit an extra data grant. Finally, the bench retires entry 5 and checks that the next miss reuses it. It holds an instruction fetch behind pending data entries and a snoop, which catches an instruction request that jumps ahead of data or is dropped.

// File: rtl/l2arb_pkg.sv
package l2arb_pkg;

    parameter int ADDR_W     = 32;
    parameter int DEPTH      = 8;
    parameter int LINE_OFS_W = 5;
    localparam int TAG_W     = $clog2(DEPTH);
    localparam int LINE_W    = ADDR_W - LINE_OFS_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [LINE_W-1:0] line_t;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_SNOOP = 2'd1,
        SRC_DATA  = 2'd2,
        SRC_INSN  = 2'd3
    } src_e;

    typedef enum logic {
        KIND_LOAD  = 1'b0,
        KIND_STORE = 1'b1
    } kind_e;

    typedef struct packed {
        logic  valid;
        logic  issued;
        kind_e kind;
        addr_t addr;
    } entry_t;

    typedef struct packed {
        logic  valid;
        src_e  src;
        addr_t addr;
        kind_e kind;
        tag_t  tag;
    } grant_t;

    function automatic line_t line_of(input addr_t a);
        return a[ADDR_W-1:LINE_OFS_W];
    endfunction

endpackage

// File: rtl/l2arb_pick_first.sv
module l2arb_pick_first #(
    parameter int N = 8,
    localparam int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0] req,
    output logic         found,
    output logic [W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = W'(i);
            end
        end
    end
endmodule

// File: rtl/l2arb_miss_table.sv
module l2arb_miss_table
    import l2arb_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   dc_valid,
    input  addr_t  dc_addr,
    input  kind_e  dc_kind,
    output logic   dc_ready,
    output tag_t   dc_tag,
    input  logic   issue_en,
    input  logic   cpl_valid,
    input  tag_t   cpl_tag,
    output logic   pend_found,
    output tag_t   pend_idx,
    output entry_t pend_entry
);
    entry_t ent_q [DEPTH];

    logic [DEPTH-1:0] valid_vec;
    logic [DEPTH-1:0] free_vec;
    logic [DEPTH-1:0] pend_vec;
    logic [DEPTH-1:0] retire_vec;
    logic [DEPTH-1:0] match_vec;

    logic hit, free_found, alloc;
    tag_t hit_idx, free_idx;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            valid_vec[i]  = ent_q[i].valid;
            free_vec[i]   = !ent_q[i].valid;
            pend_vec[i]   = ent_q[i].valid && !ent_q[i].issued;
            retire_vec[i] = cpl_valid && (cpl_tag == tag_t'(i));
            match_vec[i]  = ent_q[i].valid && !retire_vec[i]
                            && (line_of(ent_q[i].addr) == line_of(dc_addr));
        end
    end

    l2arb_pick_first #(.N(DEPTH)) i_pick_hit (
        .req(match_vec), .found(hit), .idx(hit_idx)
    );
    l2arb_pick_first #(.N(DEPTH)) i_pick_free (
        .req(free_vec), .found(free_found), .idx(free_idx)
    );
    l2arb_pick_first #(.N(DEPTH)) i_pick_pend (
        .req(pend_vec), .found(pend_found), .idx(pend_idx)
    );

    assign pend_entry = ent_q[pend_idx];
    assign dc_ready   = hit || free_found;
    assign dc_tag     = hit ? hit_idx : free_idx;
    assign alloc      = dc_valid && !hit && free_found;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                ent_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (retire_vec[i]) begin
                    ent_q[i].valid  <= 1'b0;
                    ent_q[i].issued <= 1'b0;
                end else if (alloc && free_idx == tag_t'(i)) begin
                    ent_q[i].valid  <= 1'b1;
                    ent_q[i].issued <= 1'b0;
                    ent_q[i].kind   <= dc_kind;
                    ent_q[i].addr   <= dc_addr;
                end else if (issue_en && pend_idx == tag_t'(i)) begin
                    ent_q[i].issued <= 1'b1;
                end
            end
        end
    end

    AST_FULL_STALL: assert property (@(posedge clk) disable iff (rst)
        ($countones(valid_vec) == DEPTH && !hit) |-> !dc_ready); // R7

    AST_MERGE_NO_ALLOC: assert property (@(posedge clk) disable iff (rst)
        (dc_valid && hit) |=> ($countones(valid_vec) <= $past($countones(valid_vec)))); // R8

    AST_RETIRE_FREES: assert property (@(posedge clk) disable iff (rst)
        (cpl_valid && ent_q[cpl_tag].valid) |=> !ent_q[$past(cpl_tag)].valid); // R9

    AST_ISSUE_ONCE: assert property (@(posedge clk) disable iff (rst)
        issue_en |-> (ent_q[pend_idx].valid && !ent_q[pend_idx].issued)); // R10

endmodule

// File: rtl/l2arb_prio_select.sv
module l2arb_prio_select
    import l2arb_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   snp_valid,
    input  addr_t  snp_addr,
    input  logic   pend_found,
    input  tag_t   pend_idx,
    input  entry_t pend_entry,
    input  logic   ic_valid,
    input  addr_t  ic_addr,
    output logic   ic_ready,
    output logic   issue_en,
    output grant_t sel
);
    logic take_snp, take_data, take_insn;

    assign take_snp  = snp_valid;
    assign take_data = !snp_valid && pend_found;
    assign take_insn = !snp_valid && !pend_found && ic_valid;

    assign ic_ready = take_insn;
    assign issue_en = take_data;

    always_comb begin
        sel = '0;
        if (take_snp) begin
            sel.valid = 1'b1;
            sel.src   = SRC_SNOOP;
            sel.addr  = snp_addr;
        end else if (take_data) begin
            sel.valid = 1'b1;
            sel.src   = SRC_DATA;
            sel.addr  = pend_entry.addr;
            sel.kind  = pend_entry.kind;
            sel.tag   = pend_idx;
        end else if (take_insn) begin
            sel.valid = 1'b1;
            sel.src   = SRC_INSN;
            sel.addr  = ic_addr;
        end
    end

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({take_snp, take_data, take_insn})); // R5

endmodule

// File: rtl/l2_req_arbiter.sv
module l2_req_arbiter
    import l2arb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              snp_valid,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic              dc_valid,
    input  logic [ADDR_W-1:0] dc_addr,
    input  logic              dc_store,
    output logic              dc_ready,
    output logic [TAG_W-1:0]  dc_tag,
    input  logic              ic_valid,
    input  logic [ADDR_W-1:0] ic_addr,
    output logic              ic_ready,
    input  logic              cpl_valid,
    input  logic [TAG_W-1:0]  cpl_tag,
    output logic              gnt_valid,
    output logic [1:0]        gnt_src,
    output logic [ADDR_W-1:0] gnt_addr,
    output logic              gnt_store,
    output logic [TAG_W-1:0]  gnt_tag
);
    logic   pend_found, issue_en;
    tag_t   pend_idx;
    entry_t pend_entry;
    grant_t sel, gnt_q;

    l2arb_miss_table i_table (
        .clk       (clk),
        .rst       (rst),
        .dc_valid  (dc_valid),
        .dc_addr   (dc_addr),
        .dc_kind   (kind_e'(dc_store)),
        .dc_ready  (dc_ready),
        .dc_tag    (dc_tag),
        .issue_en  (issue_en),
        .cpl_valid (cpl_valid),
        .cpl_tag   (cpl_tag),
        .pend_found(pend_found),
        .pend_idx  (pend_idx),
        .pend_entry(pend_entry)
    );

    l2arb_prio_select i_prio (
        .clk       (clk),
        .rst       (rst),
        .snp_valid (snp_valid),
        .snp_addr  (snp_addr),
        .pend_found(pend_found),
        .pend_idx  (pend_idx),
        .pend_entry(pend_entry),
        .ic_valid  (ic_valid),
        .ic_addr   (ic_addr),
        .ic_ready  (ic_ready),
        .issue_en  (issue_en),
        .sel       (sel)
    );

    always_ff @(posedge clk) begin
        if (rst) gnt_q <= '0;
        else     gnt_q <= sel;
    end

    assign gnt_valid = gnt_q.valid;
    assign gnt_src   = gnt_q.src;
    assign gnt_addr  = gnt_q.addr;
    assign gnt_store = gnt_q.kind;
    assign gnt_tag   = gnt_q.tag;

    AST_SNOOP_FIRST: assert property (@(posedge clk) disable iff (rst)
        snp_valid |=> (gnt_valid && gnt_src == SRC_SNOOP && gnt_addr == $past(snp_addr))); // R1

    AST_INSN_GRANT: assert property (@(posedge clk) disable iff (rst)
        ic_ready |=> (gnt_src == SRC_INSN && gnt_addr == $past(ic_addr))); // R3

    AST_IDLE_SRC: assert property (@(posedge clk) disable iff (rst)
        !gnt_valid |-> gnt_src == SRC_NONE); // R5

endmodule

// File: tb/test_l2_req_arbiter.sv
module test_l2_req_arbiter;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        snp_valid = 0, dc_valid = 0, dc_store = 0, ic_valid = 0, cpl_valid = 0;
    logic [31:0] snp_addr = '0, dc_addr = '0, ic_addr = '0;
    logic [2:0]  cpl_tag = '0;
    logic        dc_ready, ic_ready, gnt_valid, gnt_store;
    logic [2:0]  dc_tag, gnt_tag;
    logic [1:0]  gnt_src;
    logic [31:0] gnt_addr;

    int checks = 0, fails = 0, cycles = 0;
    bit done = 0;

    always #5 clk = ~clk;

    l2_req_arbiter i_l2_req_arbiter (.*);

    // vector: [6]snp [5]ic [4]dc [3]exp ic_ready [2:1]exp src [0]exp data grant after
    localparam logic [6:0] VEC [8] = '{
        7'b000_0_00_0, 7'b001_0_00_1, 7'b010_1_11_0, 7'b011_1_11_1,
        7'b100_0_01_0, 7'b101_0_01_1, 7'b110_0_01_0, 7'b111_0_01_1
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                checks++;
                fails++;
                $display("FAIL watchdog: actual %0d expected below 20000", cycles);
                finish_run();
            end
        end
    end

    initial begin
        step(); step();
        rst = 0;
        #1;
        check("R5 reset gnt_valid", gnt_valid, 0);
        check("R5 reset gnt_src", gnt_src, 0);
        check("R6 reset dc_ready", dc_ready, 1);
        check("R3 reset ic_ready", ic_ready, 0);

        // priority vectors on an empty table
        for (int v = 0; v < 8; v++) begin
            snp_valid = VEC[v][6]; ic_valid = VEC[v][5]; dc_valid = VEC[v][4];
            snp_addr = 32'hA000 + v; ic_addr = 32'hB000 + v; dc_addr = 32'hC000 + 32'(v * 64);
            dc_store = v[0];
            #1;
            check("R3/R4 ic_ready", ic_ready, VEC[v][3]);
            check("R4/R6 dc_ready", dc_ready, 1);
            check("R6 dc_tag", dc_tag, 0);
            step();
            snp_valid = 0; ic_valid = 0; dc_valid = 0;
            check("R1/R3 gnt_src", gnt_src, 32'(VEC[v][2:1]));
            check("R5 gnt_valid", gnt_valid, VEC[v][2:1] != 0);
            if (VEC[v][2:1] == 2'd1) check("R1 gnt_addr", gnt_addr, 32'hA000 + v);
            if (VEC[v][2:1] == 2'd3) check("R3 gnt_addr", gnt_addr, 32'hB000 + v);
            step();
            check("R2 data grant", gnt_valid, VEC[v][0]);
            if (VEC[v][0]) begin
                check("R2 data src", gnt_src, 2);
                check("R2 data tag", gnt_tag, 0);
                check("R2 data addr", gnt_addr, 32'hC000 + 32'(v * 64));
                check("R2 data kind", gnt_store, v[0]);
            end
            cpl_valid = VEC[v][0]; cpl_tag = 0;
            step();
            cpl_valid = 0;
        end

        // fill all eight entries
        for (int i = 0; i < 8; i++) begin
            dc_valid = 1; dc_addr = 32'h1000 + 32'(i * 32); dc_store = 0;
            #1;
            check("R6 fill ready", dc_ready, 1);
            check("R6 fill tag", dc_tag, 32'(i));
            step();
            if (i > 0) begin
                check("R10 fill grant src", gnt_src, 2);
                check("R10 fill grant tag", gnt_tag, 32'(i - 1));
            end
        end
        dc_addr = 32'h9000;
        #1;
        check("R7 full refuses new line", dc_ready, 0);
        dc_valid = 0;
        step();
        check("R10 last fill grant tag", gnt_tag, 7);
        check("R10 last fill grant addr", gnt_addr, 32'h1000 + 32'(7 * 32));

        // merge into entry 3 while full
        dc_valid = 1; dc_addr = 32'h1000 + 32'(3 * 32) + 32'h4; dc_store = 1;
        #1;
        check("R8 merge ready when full", dc_ready, 1);
        check("R8 merge tag", dc_tag, 3);
        step();
        dc_valid = 0;
        step();
        check("R8 no grant after merge", gnt_valid, 0);

        // retire entry 5 and reuse it
        cpl_valid = 1; cpl_tag = 5;
        step();
        cpl_valid = 0;
        dc_valid = 1; dc_addr = 32'h7700; dc_store = 1;
        #1;
        check("R9 reuse ready", dc_ready, 1);
        check("R9 reuse tag", dc_tag, 5);
        step();
        dc_valid = 0;
        step();
        check("R9 reused entry granted tag", gnt_tag, 5);
        check("R9 reused entry addr", gnt_addr, 32'h7700);
        check("R9 reused entry kind", gnt_store, 1);

        // drain the table
        for (int i = 0; i < 8; i++) begin
            cpl_valid = 1; cpl_tag = 3'(i);
            step();
        end
        cpl_valid = 0;

        // instruction held behind a pending data entry
        dc_valid = 1; dc_addr = 32'h2000; dc_store = 0;
        step();
        dc_valid = 0; ic_valid = 1; ic_addr = 32'h3000;
        #1;
        check("R3 insn waits for data", ic_ready, 0);
        step();
        check("R2 data before insn", gnt_src, 2);
        #1;
        check("R3 held insn now ready", ic_ready, 1);
        step();
        ic_valid = 0;
        check("R3 held insn granted", gnt_src, 3);
        check("R3 held insn addr", gnt_addr, 32'h3000);

        // snoop ahead of pending data and held instruction
        dc_valid = 1; dc_addr = 32'h2400;
        step();
        dc_valid = 0; snp_valid = 1; snp_addr = 32'h5500; ic_valid = 1; ic_addr = 32'h3100;
        #1;
        check("R3 insn refused under snoop", ic_ready, 0);
        step();
        snp_valid = 0;
        check("R1 snoop first", gnt_src, 1);
        check("R1 snoop addr", gnt_addr, 32'h5500);
        #1;
        check("R3 insn still waits", ic_ready, 0);
        step();
        check("R2 data second", gnt_src, 2);
        check("R2 data second tag", gnt_tag, 1);
        #1;
        check("R3 insn last ready", ic_ready, 1);
        step();
        ic_valid = 0;
        check("R3 insn last", gnt_src, 3);
        step();
        check("R5 idle after", gnt_valid, 0);

        finish_run();
    end
endmodule